// File: doc/BRIEF.md
# Voice Interrupt Acknowledge Scanner

This block tracks which synthesizer voices have raised an end-of-sample or an end-of-volume-ramp interrupt, and hands them to the host one at a time. Each voice engine pulses a set strobe for its source. The block keeps one pending vector per source, a two-bit slice of the global interrupt status, and an interrupt line.

The host drives a small register port. Address 0 is the function select register and address 1 is the data register. Writing the acknowledge code to the function select register starts one scan. The scan picks the lowest pending voice, with end-of-sample sources taking priority over ramp sources. It clears that voice's pending bit and pulses a clear strobe toward that voice's own control register flag. It then latches a result byte that encodes both the source and the voice number, and the host reads that byte back through the data register. A data write of function 0x4C with bit 0 low is the soft reset. It discards every pending interrupt.

Top module: `voice_irq_ack`

## Requirements
- R1: After rst_n low, irq is 0, irq_status is 0x00, the function select reads back as 0x00, and no clear strobe is active.
- R2: A pulse on any wave_set bit sets irq_status bit 5, and a pulse on any ramp_set bit sets irq_status bit 6. In both cases irq is high from the next clock edge.
- R3: Writing 0x8F to address 0 triggers exactly one scan. A read of address 1 returns the latched result byte while the function select holds 0x8F, and returns 0xFF for any other function. A read of address 0 returns the function select.
- R4: When any end-of-sample bit is pending, the scan acknowledges an end-of-sample voice and leaves the ramp vector untouched.
- R5: Within the chosen source, the lowest-numbered pending voice is acknowledged, and only one voice is acknowledged per trigger.
- R6: The result byte is 0x60 OR voice for an end-of-sample acknowledge and 0x80 OR voice for a ramp acknowledge.
- R7: When no bit is pending in either vector, the result is 0xE8 and no clear strobe fires.
- R8: The acknowledged voice's pending bit is cleared. For one cycle after the trigger edge, exactly one bit of wave_flag_clr (end-of-sample) or of ramp_flag_clr (ramp) is high, at that voice's position.
- R9: After an acknowledge empties a vector, its irq_status bit (5 or 6) clears. While other voices of that source remain pending, the bit stays set.
- R10: irq falls only once both status bits are zero. It stays high while either bit is set.
- R11: With function 0x4C selected, a data write with bit 0 clear empties both vectors, clears irq_status and lowers irq. A data write with bit 0 set leaves them unchanged.
- R12: If a set strobe and an acknowledge hit the same voice in the same cycle, that voice stays pending.
- R13: Only voices 0 to 30 are scanned. If the end-of-sample vector holds only voice 31, the result is 0xE8, no strobe fires, and the ramp vector is not examined.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wave_set | input | NUM_VOICES | End-of-sample interrupt set strobes, one per voice |
| ramp_set | input | NUM_VOICES | End-of-ramp interrupt set strobes, one per voice |
| wr_en | input | 1 | Host register write enable |
| wr_addr | input | 1 | 0 = function select, 1 = data |
| wr_data | input | 8 | Host write data |
| rd_addr | input | 1 | 0 = function select, 1 = data |
| rd_data | output | 8 | Host read data (combinational) |
| wave_flag_clr | output | NUM_VOICES | One-cycle clear of a voice's wave control flag |
| ramp_flag_clr | output | NUM_VOICES | One-cycle clear of a voice's ramp control flag |
| irq_status | output | 8 | Global status slice: bit 5 end-of-sample, bit 6 ramp |
| irq | output | 1 | Interrupt line |

## Verification
The bench uses the default parameters: 32 voices per vector, 31 of them scanned. With these values voice 31 can be pending but is never acknowledged, which makes the "wave vector non-empty but nothing found" path of R13 reachable. Voice 30 is the highest voice the scan can acknowledge, which exercises the top of the encoding. The directed tests cover priority between sources, ordering within a source, same-cycle collisions and the soft reset.

// File: rtl/voice_irq_ack_pkg.sv
`timescale 1ns/1ps
// Shared constants and helpers for the voice interrupt acknowledge scanner.
package voice_irq_ack_pkg;
    localparam logic [7:0] FN_ACK      = 8'h8F;
    localparam logic [7:0] FN_SOFT_RST = 8'h4C;
    localparam logic [7:0] TAG_WAVE    = 8'h60;
    localparam logic [7:0] TAG_RAMP    = 8'h80;
    localparam logic [7:0] RES_EMPTY   = 8'hE8;
    localparam logic [7:0] RD_UNMAPPED = 8'hFF;
    localparam int         STAT_WAVE_BIT = 5;
    localparam int         STAT_RAMP_BIT = 6;

    typedef enum logic {REG_FUNC = 1'b0, REG_DATA = 1'b1} reg_addr_e;

    // Merge a source tag with a voice number into a result byte.
    function automatic logic [7:0] encode_result(input logic [7:0] tag, input logic [7:0] voice);
        return tag | voice;
    endfunction
endpackage

// File: rtl/pending_vec.sv
`timescale 1ns/1ps
// Pending-interrupt vector for one source.
// A set strobe dominates a same-cycle clear on its bit; wipe dominates both.
// Also exposes the next-state vector so the parent can judge emptiness.
module pending_vec #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wipe,
    input  logic [W-1:0] set,
    input  logic [W-1:0] clr,
    output logic [W-1:0] vec,
    output logic [W-1:0] vec_nxt
);
    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_bit
            // Next value of one pending bit.
            assign vec_nxt[i] = wipe ? 1'b0 : (set[i] | (vec[i] & ~clr[i]));
            // Hold one pending bit.
            always_ff @(posedge clk) begin
                if (!rst_n) vec[i] <= 1'b0;
                else        vec[i] <= vec_nxt[i];
            end
        end
    endgenerate
endmodule

// File: rtl/lowest_pick.sv
`timescale 1ns/1ps
// Lowest-index priority picker: one-hot grant plus binary index.
// Assumes W >= 2. Purely combinational.
module lowest_pick #(
    parameter int W  = 31,
    localparam int IW = $clog2(W)
) (
    input  logic [W-1:0]  req,
    output logic          found,
    output logic [W-1:0]  grant,
    output logic [IW-1:0] idx
);
    logic [W:0] seen;
    assign seen[0] = 1'b0;

    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_chain
            assign grant[i]  = req[i] & ~seen[i];
            assign seen[i+1] = seen[i] | req[i];
        end
    endgenerate

    assign found = seen[W];

    // Encode the one-hot grant into a voice number.
    always_comb begin
        idx = '0;
        for (int k = 0; k < W; k++) begin
            if (grant[k]) idx = idx | IW'(k);
        end
    end
endmodule

// File: rtl/voice_irq_ack.sv
`timescale 1ns/1ps
// Voice interrupt acknowledge scanner.
// Holds end-of-sample and end-of-ramp pending vectors, serves one voice per
// host acknowledge write (sample sources first, lowest voice first), latches
// an encoded result byte and drives the global status slice and irq line.
// Assumes NUM_VOICES <= 32 and 2 <= SCAN_VOICES <= NUM_VOICES.
module voice_irq_ack
    import voice_irq_ack_pkg::*;
#(
    parameter int NUM_VOICES  = 32,
    parameter int SCAN_VOICES = 31
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_VOICES-1:0] wave_set,
    input  logic [NUM_VOICES-1:0] ramp_set,
    input  logic                  wr_en,
    input  logic                  wr_addr,
    input  logic [7:0]            wr_data,
    input  logic                  rd_addr,
    output logic [7:0]            rd_data,
    output logic [NUM_VOICES-1:0] wave_flag_clr,
    output logic [NUM_VOICES-1:0] ramp_flag_clr,
    output logic [7:0]            irq_status,
    output logic                  irq
);
    localparam int IW  = $clog2(SCAN_VOICES);
    localparam int PAD = NUM_VOICES - SCAN_VOICES;

    logic [7:0] func_q;
    logic [7:0] result_q, result_d;
    logic       wave_stat_q, ramp_stat_q, wave_stat_d, ramp_stat_d;
    logic       ack_wr, soft_rst_wr;

    logic [NUM_VOICES-1:0] wave_vec, wave_nxt, ramp_vec, ramp_nxt;
    logic [NUM_VOICES-1:0] wave_clr, ramp_clr;
    logic                  wave_found, ramp_found;
    logic [SCAN_VOICES-1:0] wave_grant, ramp_grant;
    logic [IW-1:0]         wave_idx, ramp_idx;
    logic                  take_wave, take_ramp;

    // Decode host writes into scan trigger and soft reset.
    assign ack_wr      = wr_en && (wr_addr == REG_FUNC) && (wr_data == FN_ACK);
    assign soft_rst_wr = wr_en && (wr_addr == REG_DATA) && (func_q == FN_SOFT_RST) && !wr_data[0];

    // Function select register.
    always_ff @(posedge clk) begin
        if (!rst_n)                          func_q <= 8'h00;
        else if (wr_en && wr_addr == REG_FUNC) func_q <= wr_data;
    end

    lowest_pick #(.W(SCAN_VOICES)) u_pick_wave (
        .req(wave_vec[SCAN_VOICES-1:0]), .found(wave_found), .grant(wave_grant), .idx(wave_idx)
    );
    lowest_pick #(.W(SCAN_VOICES)) u_pick_ramp (
        .req(ramp_vec[SCAN_VOICES-1:0]), .found(ramp_found), .grant(ramp_grant), .idx(ramp_idx)
    );

    // Source arbitration: any sample bit (scanned or not) blocks the ramp scan.
    always_comb begin
        take_wave = 1'b0;
        take_ramp = 1'b0;
        result_d  = RES_EMPTY;
        if (|wave_vec) begin
            if (wave_found) begin
                take_wave = 1'b1;
                result_d  = encode_result(TAG_WAVE, 8'(wave_idx));
            end
        end else if (|ramp_vec) begin
            if (ramp_found) begin
                take_ramp = 1'b1;
                result_d  = encode_result(TAG_RAMP, 8'(ramp_idx));
            end
        end
    end

    // Widen grants to the vector width, padding unscanned voices with zero.
    generate
        if (PAD > 0) begin : g_pad
            assign wave_clr = (ack_wr && take_wave) ? {{PAD{1'b0}}, wave_grant} : '0;
            assign ramp_clr = (ack_wr && take_ramp) ? {{PAD{1'b0}}, ramp_grant} : '0;
        end else begin : g_nopad
            assign wave_clr = (ack_wr && take_wave) ? wave_grant : '0;
            assign ramp_clr = (ack_wr && take_ramp) ? ramp_grant : '0;
        end
    endgenerate

    pending_vec #(.W(NUM_VOICES)) u_wave_vec (
        .clk(clk), .rst_n(rst_n), .wipe(soft_rst_wr), .set(wave_set),
        .clr(wave_clr), .vec(wave_vec), .vec_nxt(wave_nxt)
    );
    pending_vec #(.W(NUM_VOICES)) u_ramp_vec (
        .clk(clk), .rst_n(rst_n), .wipe(soft_rst_wr), .set(ramp_set),
        .clr(ramp_clr), .vec(ramp_vec), .vec_nxt(ramp_nxt)
    );

    // Next global status bits: set on any strobe, cleared when an ack empties the vector.
    always_comb begin
        wave_stat_d = wave_stat_q;
        ramp_stat_d = ramp_stat_q;
        if (soft_rst_wr) begin
            wave_stat_d = 1'b0;
            ramp_stat_d = 1'b0;
        end else begin
            if (|wave_set)                     wave_stat_d = 1'b1;
            else if ((|wave_clr) && !(|wave_nxt)) wave_stat_d = 1'b0;
            if (|ramp_set)                     ramp_stat_d = 1'b1;
            else if ((|ramp_clr) && !(|ramp_nxt)) ramp_stat_d = 1'b0;
        end
    end

    // Status, interrupt line, result byte and flag-clear strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wave_stat_q   <= 1'b0;
            ramp_stat_q   <= 1'b0;
            irq           <= 1'b0;
            result_q      <= RES_EMPTY;
            wave_flag_clr <= '0;
            ramp_flag_clr <= '0;
        end else begin
            wave_stat_q   <= wave_stat_d;
            ramp_stat_q   <= ramp_stat_d;
            irq           <= wave_stat_d | ramp_stat_d;
            if (ack_wr) result_q <= result_d;
            wave_flag_clr <= wave_clr;
            ramp_flag_clr <= ramp_clr;
        end
    end

    // Place the two owned bits into the status byte.
    always_comb begin
        irq_status = 8'h00;
        irq_status[STAT_WAVE_BIT] = wave_stat_q;
        irq_status[STAT_RAMP_BIT] = ramp_stat_q;
    end

    // Host read mux.
    always_comb begin
        if (rd_addr == REG_FUNC)    rd_data = func_q;
        else if (func_q == FN_ACK)  rd_data = result_q;
        else                        rd_data = RD_UNMAPPED;
    end
endmodule

// File: rtl/voice_irq_ack_chk.sv
`timescale 1ns/1ps
// Protocol checker for voice_irq_ack, attached by bind.
module voice_irq_ack_chk
    import voice_irq_ack_pkg::*;
#(
    parameter int NUM_VOICES  = 32,
    parameter int SCAN_VOICES = 31
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [NUM_VOICES-1:0] wave_set,
    input logic [NUM_VOICES-1:0] ramp_set,
    input logic                  ack_wr,
    input logic                  soft_rst_wr,
    input logic [NUM_VOICES-1:0] wave_vec,
    input logic [NUM_VOICES-1:0] ramp_vec,
    input logic [NUM_VOICES-1:0] wave_flag_clr,
    input logic [NUM_VOICES-1:0] ramp_flag_clr,
    input logic [7:0]            result_q,
    input logic [7:0]            irq_status,
    input logic                  irq
);
    assert_single_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wave_flag_clr, ramp_flag_clr}));

    assert_set_raises_irq_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((|wave_set) || (|ramp_set)) && !soft_rst_wr |=> irq);

    assert_soft_reset_R11: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_wr |=> !irq && irq_status == 8'h00 && wave_vec == '0 && ramp_vec == '0);

    assert_wave_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_wr && !soft_rst_wr && (|wave_vec[SCAN_VOICES-1:0])) |=> (|wave_flag_clr) && ramp_flag_clr == '0);

    assert_empty_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_wr && wave_vec == '0 && ramp_vec == '0) |=> result_q == RES_EMPTY && ramp_flag_clr == '0 && wave_flag_clr == '0);

    assert_ramp_tag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|ramp_flag_clr) |-> result_q[7:5] == 3'b100);

    assert_irq_tracks_status_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> irq_status == 8'h00);
endmodule

bind voice_irq_ack voice_irq_ack_chk #(.NUM_VOICES(NUM_VOICES), .SCAN_VOICES(SCAN_VOICES)) u_chk (
    .clk(clk), .rst_n(rst_n), .wave_set(wave_set), .ramp_set(ramp_set),
    .ack_wr(ack_wr), .soft_rst_wr(soft_rst_wr), .wave_vec(wave_vec), .ramp_vec(ramp_vec),
    .wave_flag_clr(wave_flag_clr), .ramp_flag_clr(ramp_flag_clr), .result_q(result_q),
    .irq_status(irq_status), .irq(irq)
);

// File: tb/voice_irq_ack_bench.sv
`timescale 1ns/1ps
// Directed bench for voice_irq_ack: one task per scenario.
module voice_irq_ack_bench;
    localparam int NV = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NV-1:0] wave_set = '0;
    logic [NV-1:0] ramp_set = '0;
    logic          wr_en = 1'b0;
    logic          wr_addr = 1'b0;
    logic [7:0]    wr_data = 8'h00;
    logic          rd_addr = 1'b0;
    logic [7:0]    rd_data;
    logic [NV-1:0] wave_flag_clr, ramp_flag_clr;
    logic [7:0]    irq_status;
    logic          irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    voice_irq_ack u_voice_irq_ack (
        .clk(clk), .rst_n(rst_n), .wave_set(wave_set), .ramp_set(ramp_set),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .wave_flag_clr(wave_flag_clr), .ramp_flag_clr(ramp_flag_clr),
        .irq_status(irq_status), .irq(irq)
    );

    always #2.5 clk = ~clk;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // One host write; outputs are settled at the returning negedge.
    task automatic host_wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_set(input logic [NV-1:0] w, input logic [NV-1:0] r);
        @(negedge clk);
        wave_set = w; ramp_set = r;
        @(negedge clk);
        wave_set = '0; ramp_set = '0;
    endtask

    // Trigger a scan, check the result byte and the strobes.
    task automatic ack_expect(input string req, input logic [7:0] res,
                              input logic [NV-1:0] wclr, input logic [NV-1:0] rclr);
        host_wr(1'b0, 8'h8F);
        check({req, " wave strobe"}, 64'(wave_flag_clr), 64'(wclr));
        check({req, " ramp strobe"}, 64'(ramp_flag_clr), 64'(rclr));
        rd_addr = 1'b1; #0.1;
        check({req, " result"}, 64'(rd_data), 64'(res));
    endtask

    task automatic t_reset;
        check("R1 irq", 64'(irq), 64'd0);
        check("R1 status", 64'(irq_status), 64'h00);
        check("R1 strobes", 64'({wave_flag_clr, ramp_flag_clr}), 64'd0);
        rd_addr = 1'b0; #0.1;
        check("R1 func", 64'(rd_data), 64'h00);
        rd_addr = 1'b1; #0.1;
        check("R3 unmapped read", 64'(rd_data), 64'hFF);
        ack_expect("R7 empty", 8'hE8, '0, '0);
        rd_addr = 1'b0; #0.1;
        check("R3 func readback", 64'(rd_data), 64'h8F);
    endtask

    task automatic t_single_wave;
        pulse_set(NV'(1) << 3, '0);
        check("R2 wave status", 64'(irq_status), 64'h20);
        check("R2 irq", 64'(irq), 64'd1);
        ack_expect("R6 R8 wave voice3", 8'h63, NV'(1) << 3, '0);
        check("R9 wave status cleared", 64'(irq_status), 64'h00);
        check("R10 irq dropped", 64'(irq), 64'd0);
        ack_expect("R8 bit gone", 8'hE8, '0, '0);
    endtask

    task automatic t_priority;
        pulse_set(NV'(1) << 9, NV'(1) << 2);
        check("R2 both status", 64'(irq_status), 64'h60);
        ack_expect("R4 wave first", 8'h69, NV'(1) << 9, '0);
        check("R9 only ramp left", 64'(irq_status), 64'h40);
        check("R10 irq held", 64'(irq), 64'd1);
        ack_expect("R6 ramp voice2", 8'h82, '0, NV'(1) << 2);
        check("R10 irq low", 64'(irq), 64'd0);
    endtask

    task automatic t_lowest;
        pulse_set((NV'(1) << 30) | (NV'(1) << 17) | (NV'(1) << 5), '0);
        ack_expect("R5 first", 8'h65, NV'(1) << 5, '0);
        check("R9 stays set", 64'(irq_status), 64'h20);
        ack_expect("R5 second", 8'h71, NV'(1) << 17, '0);
        ack_expect("R5 third", 8'h7E, NV'(1) << 30, '0);
        check("R9 now clear", 64'(irq_status), 64'h00);
        ack_expect("R5 drained", 8'hE8, '0, '0);
    endtask

    task automatic t_collision;
        pulse_set(NV'(1) << 4, '0);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 1'b0; wr_data = 8'h8F; wave_set = NV'(1) << 4;
        @(negedge clk);
        wr_en = 1'b0; wave_set = '0;
        check("R12 strobe", 64'(wave_flag_clr), 64'(NV'(1) << 4));
        check("R12 status kept", 64'(irq_status), 64'h20);
        ack_expect("R12 still pending", 8'h64, NV'(1) << 4, '0);
        check("R12 then clear", 64'(irq), 64'd0);
    endtask

    task automatic t_top_voice;
        pulse_set(NV'(1) << 31, NV'(1) << 1);
        ack_expect("R13 unscanned voice", 8'hE8, '0, '0);
        check("R13 status held", 64'(irq_status), 64'h60);
        host_wr(1'b0, 8'h4C);
        host_wr(1'b1, 8'h00);
        check("R11 status wiped", 64'(irq_status), 64'h00);
        check("R11 irq low", 64'(irq), 64'd0);
        ack_expect("R11 vectors empty", 8'hE8, '0, '0);
        pulse_set('0, NV'(1) << 6);
        host_wr(1'b0, 8'h4C);
        host_wr(1'b1, 8'h01);
        check("R11 bit0 set keeps status", 64'(irq_status), 64'h40);
        ack_expect("R11 bit0 set keeps pending", 8'h86, '0, NV'(1) << 6);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single_wave();
        t_priority();
        t_lowest();
        t_collision();
        t_top_voice();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule